// File: doc/BRIEF.md
# Threshold-Driven Digital Gain Control Loop

This block is a closed-loop gain stage for a stream of signed samples. Each sample that arrives with the valid strobe is multiplied by the current gain. The gain is an unsigned fixed-point number with `GAIN_FRAC` fractional bits. The product is clipped to an `OUT_W`-bit signed word and rounded to a programmable number of kept bits, then sent out one cycle later. The magnitude of the clipped product also feeds a classifier. The classifier decides whether the gain should grow, shrink or stay as it is.

The classifier compares the top eight bits of the magnitude with a programmable threshold. It also tracks runs of zero-valued and full-scale samples with a small state machine. The run states are `RUN_IDLE`, `RUN_ZERO` and `RUN_FULL`, and each holds a saturating length counter. Each sample moves the run state as follows:

- A full-scale sample goes to `RUN_FULL`: the count steps up if the state was already `RUN_FULL`, and restarts at one otherwise.
- A zero sample goes to `RUN_ZERO`, with the same counting rule.
- Any other valid sample returns the state to `RUN_IDLE` with the count cleared.
- Cycles without the valid strobe leave the state unchanged.

Each of the four decisions has its own 4-bit shift field. The shift field sets the step as a unit value shifted left, and that step is added to or subtracted from the gain. The gain register clamps at both ends of its range.

Top module: `agc_loop`

## Requirements
- R1: While reset is asserted, and on the first edge after it, the gain reads 2^GAIN_FRAC (4096 by default), out_valid is 0 and out_data is 0.
- R2: A sample taken with in_valid high gives out_valid high on the next cycle. The output holds the product of the sample and the gain in force before that sample's own update, arithmetically shifted right by GAIN_FRAC. In the same cycle gain_out shows the updated gain. Samples may arrive on every cycle.
- R3: The shifted product is clipped to the OUT_W-bit signed range, which is -131072 to 131071 by default.
- R4: The magnitude is |clipped product|, clamped to 2^(OUT_W-1)-1. If its top 8 bits are above thres, the gain drops by 1<<step_above. If they are below thres, the gain rises by 1<<step_below. If they are equal, the gain does not change.
- R5: A sample is zero when its magnitude, with the low zero_mask bits ignored, equals 0. On the 4th and every later consecutive valid zero sample, the gain rises by 1<<step_zero, and this replaces the threshold decision.
- R6: A sample is full-scale when its magnitude is all ones. On the 4th and every later consecutive valid full-scale sample, the gain drops by 1<<step_full. This decision has priority over the zero and threshold decisions.
- R7: zero_mask (0..15) is the number of low magnitude bits that count as zero for the zero test only.
- R8: A valid sample of another class ends a run. A zero or full-scale sample that has not yet reached the 4th position of its run is judged by the threshold rule.
- R9: The gain clamps at 0 and at 2^GAIN_W-1 instead of wrapping.
- R10: With rnd_code = c > 0, out_data is the clipped product plus 2^(c-1), with the low c bits cleared (round half up). The low c bits of out_data are always zero. With c = 0 the full word is passed through.
- R11: If rounding pushes the value past the positive limit, out_data becomes 2^(OUT_W-1) - 2^c.
- R12: Without in_valid the gain stays unchanged and out_valid is 0, whatever in_data carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Signed input sample |
| thres | input | THR_W | Threshold for the top magnitude bits |
| step_below | input | SHIFT_W | Shift for the below-threshold step (add) |
| step_above | input | SHIFT_W | Shift for the above-threshold step (subtract) |
| step_zero | input | SHIFT_W | Shift for the sustained-zero step (add) |
| step_full | input | SHIFT_W | Shift for the sustained-full-scale step (subtract) |
| zero_mask | input | MASK_W | Count of low magnitude bits ignored by the zero test |
| rnd_code | input | RND_W | Number of low output bits rounded away |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_data | output | OUT_W | Scaled, clipped and rounded sample |
| gain_out | output | GAIN_W | Current gain accumulator |

## Verification
The bench builds the block with its defaults: 16-bit samples, a 16-bit gain with 12 fractional bits, an 18-bit output and runs of 4. With these settings the gain can reach almost sixteen, so a full-scale 16-bit input overflows the 18-bit output, and the clip and full-scale run paths can be reached. Shift fields up to 15 make a single step half the gain range, so both gain clamps can be hit within a few samples. A mask of 3 turns small non-zero samples into zero runs.

// File: rtl/agc_pkg.sv
package agc_pkg;

    // direction of a gain update
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_ADD  = 2'd1,
        UPD_SUB  = 2'd2
    } upd_dir_e;

    // which shift field sizes the step
    typedef enum logic [1:0] {
        SEL_BELOW = 2'd0,
        SEL_ABOVE = 2'd1,
        SEL_ZERO  = 2'd2,
        SEL_FULL  = 2'd3
    } step_sel_e;

    // run tracker states
    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_ZERO = 2'd1,
        RUN_FULL = 2'd2
    } run_state_e;

    typedef struct packed {
        upd_dir_e  dir;
        step_sel_e sel;
    } upd_req_t;

endpackage

// File: rtl/agc_scale.sv
module agc_scale #(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int OUT_W     = 18
) (
    input  logic [DATA_W-1:0]        smp,
    input  logic [GAIN_W-1:0]        gain,
    output logic signed [OUT_W-1:0]  y,
    output logic [OUT_W-2:0]         mag
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam int MAG_W  = OUT_W - 1;

    localparam logic signed [PROD_W-1:0] P_HI =
        {{(PROD_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] P_LO =
        {{(PROD_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [OUT_W-1:0] Y_HI = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] Y_LO = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [OUT_W-1:0]  neg_y;

    always_comb begin
        prod    = $signed(smp) * $signed({1'b0, gain});
        shifted = prod >>> GAIN_FRAC;
        if (shifted > P_HI) begin
            y = Y_HI;
        end else if (shifted < P_LO) begin
            y = Y_LO;
        end else begin
            y = shifted[OUT_W-1:0];
        end
    end

    always_comb begin
        neg_y = -y;
        if (!y[OUT_W-1]) begin
            mag = y[MAG_W-1:0];
        end else if (y == Y_LO) begin
            mag = '1;
        end else begin
            mag = neg_y[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/agc_classify.sv
module agc_classify
    import agc_pkg::*;
#(
    parameter int MAG_W   = 17,
    parameter int THR_W   = 8,
    parameter int MASK_W  = 4,
    parameter int RUN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [MAG_W-1:0]  mag,
    input  logic [THR_W-1:0]  thres,
    input  logic [MASK_W-1:0] zero_mask,
    output upd_req_t          req
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    run_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              is_full, is_zero;
    logic [MAG_W-1:0]  keep_bits;
    logic [THR_W-1:0]  top;
    logic [CNT_W-1:0]  cnt_bump;

    always_comb begin
        is_full   = &mag;
        keep_bits = {MAG_W{1'b1}} << zero_mask;
        is_zero   = !is_full && ((mag & keep_bits) == '0);
        top       = mag[MAG_W-1 -: THR_W];
        cnt_bump  = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RUN_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (smp_valid) begin
            unique case (state)
                RUN_IDLE: begin
                    if (is_full) begin
                        state_n = RUN_FULL;
                        cnt_n   = CNT_ONE;
                    end else if (is_zero) begin
                        state_n = RUN_ZERO;
                        cnt_n   = CNT_ONE;
                    end
                end
                RUN_ZERO: begin
                    if (is_zero) begin
                        cnt_n   = cnt_bump;
                    end else if (is_full) begin
                        state_n = RUN_FULL;
                        cnt_n   = CNT_ONE;
                    end else begin
                        state_n = RUN_IDLE;
                        cnt_n   = '0;
                    end
                end
                RUN_FULL: begin
                    if (is_full) begin
                        cnt_n   = cnt_bump;
                    end else if (is_zero) begin
                        state_n = RUN_ZERO;
                        cnt_n   = CNT_ONE;
                    end else begin
                        state_n = RUN_IDLE;
                        cnt_n   = '0;
                    end
                end
                default: begin
                    state_n = RUN_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // decision for the current sample
    always_comb begin
        req.dir = UPD_NONE;
        req.sel = SEL_BELOW;
        if (smp_valid) begin
            if (state_n == RUN_FULL && cnt_n == CNT_TOP) begin
                req.dir = UPD_SUB;
                req.sel = SEL_FULL;
            end else if (state_n == RUN_ZERO && cnt_n == CNT_TOP) begin
                req.dir = UPD_ADD;
                req.sel = SEL_ZERO;
            end else if (top > thres) begin
                req.dir = UPD_SUB;
                req.sel = SEL_ABOVE;
            end else if (top < thres) begin
                req.dir = UPD_ADD;
                req.sel = SEL_BELOW;
            end
        end
    end

endmodule

// File: rtl/agc_gain_acc.sv
module agc_gain_acc
    import agc_pkg::*;
#(
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int SHIFT_W   = 4,
    parameter int STEP_UNIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  upd_dir_e           dir,
    input  logic [SHIFT_W-1:0] shift,
    output logic [GAIN_W-1:0]  gain
);
    localparam int EXT_W = GAIN_W + (1 << SHIFT_W) + $clog2(STEP_UNIT + 1) + 1;
    localparam logic [EXT_W-1:0]  G_MAX   = {{(EXT_W-GAIN_W){1'b0}}, {GAIN_W{1'b1}}};
    localparam logic [GAIN_W-1:0] G_UNITY = GAIN_W'(1) << GAIN_FRAC;

    logic [EXT_W-1:0]  step, gain_ext, sum, diff;
    logic [GAIN_W-1:0] gain_n;

    always_comb begin
        step     = EXT_W'(STEP_UNIT) << shift;
        gain_ext = {{(EXT_W-GAIN_W){1'b0}}, gain};
        sum      = gain_ext + step;
        diff     = gain_ext - step;
        gain_n   = gain;
        unique case (dir)
            UPD_ADD: gain_n = (sum > G_MAX) ? G_MAX[GAIN_W-1:0] : sum[GAIN_W-1:0];
            UPD_SUB: gain_n = (step > gain_ext) ? '0 : diff[GAIN_W-1:0];
            default: gain_n = gain;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain <= G_UNITY;
        end else begin
            gain <= gain_n;
        end
    end

endmodule

// File: rtl/agc_round.sv
module agc_round #(
    parameter int OUT_W = 18,
    parameter int RND_W = 4
) (
    input  logic signed [OUT_W-1:0] y,
    input  logic [RND_W-1:0]        code,
    output logic signed [OUT_W-1:0] q
);
    localparam int EW = OUT_W + 1;

    logic [EW-1:0]        keep, half, max_al;
    logic signed [EW-1:0] sum, cut;

    always_comb begin
        keep   = {EW{1'b1}} << code;
        half   = (code == '0) ? '0 : (EW'(1) << (code - 1'b1));
        sum    = {y[OUT_W-1], y} + $signed(half);
        cut    = sum & $signed(keep);
        max_al = {2'b00, {(OUT_W-1){1'b1}}} & keep;
        if (cut > $signed(max_al)) begin
            q = max_al[OUT_W-1:0];
        end else begin
            q = cut[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/agc_loop.sv
module agc_loop
    import agc_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int OUT_W     = 18,
    parameter int THR_W     = 8,
    parameter int SHIFT_W   = 4,
    parameter int MASK_W    = 4,
    parameter int RND_W     = 4,
    parameter int RUN_LEN   = 4,
    parameter int STEP_UNIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [THR_W-1:0]   thres,
    input  logic [SHIFT_W-1:0] step_below,
    input  logic [SHIFT_W-1:0] step_above,
    input  logic [SHIFT_W-1:0] step_zero,
    input  logic [SHIFT_W-1:0] step_full,
    input  logic [MASK_W-1:0]  zero_mask,
    input  logic [RND_W-1:0]   rnd_code,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_data,
    output logic [GAIN_W-1:0]  gain_out
);
    localparam int MAG_W = OUT_W - 1;

    logic signed [OUT_W-1:0] y_clip, y_rnd;
    logic [MAG_W-1:0]        mag;
    upd_req_t                req;
    logic [SHIFT_W-1:0]      shift_sel;

    agc_scale #(
        .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W)
    ) u_scale (
        .smp (in_data),
        .gain(gain_out),
        .y   (y_clip),
        .mag (mag)
    );

    agc_classify #(
        .MAG_W(MAG_W), .THR_W(THR_W), .MASK_W(MASK_W), .RUN_LEN(RUN_LEN)
    ) u_class (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(in_valid),
        .mag      (mag),
        .thres    (thres),
        .zero_mask(zero_mask),
        .req      (req)
    );

    always_comb begin
        unique case (req.sel)
            SEL_BELOW: shift_sel = step_below;
            SEL_ABOVE: shift_sel = step_above;
            SEL_ZERO:  shift_sel = step_zero;
            SEL_FULL:  shift_sel = step_full;
            default:   shift_sel = step_below;
        endcase
    end

    agc_gain_acc #(
        .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .SHIFT_W(SHIFT_W), .STEP_UNIT(STEP_UNIT)
    ) u_gain (
        .clk  (clk),
        .rst_n(rst_n),
        .dir  (req.dir),
        .shift(shift_sel),
        .gain (gain_out)
    );

    agc_round #(.OUT_W(OUT_W), .RND_W(RND_W)) u_round (
        .y   (y_clip),
        .code(rnd_code),
        .q   (y_rnd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= y_rnd;
            end
        end
    end

endmodule

// File: rtl/agc_loop_chk.sv
module agc_loop_chk #(
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 12,
    parameter int OUT_W     = 18,
    parameter int SHIFT_W   = 4,
    parameter int RND_W     = 4,
    parameter int STEP_UNIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [RND_W-1:0]  rnd_code,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_data,
    input logic [GAIN_W-1:0] gain_out
);
    localparam logic [GAIN_W-1:0] G_UNITY = GAIN_W'(1) << GAIN_FRAC;
    localparam longint MAX_STEP = longint'(STEP_UNIT) << ((1 << SHIFT_W) - 1);

    AST_RESET_UNITY: assert property (@(posedge clk)
        !rst_n |=> (gain_out == G_UNITY && !out_valid)); // R1

    AST_OUT_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R12

    AST_IDLE_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(gain_out)); // R12

    AST_ROUND_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & ~({OUT_W{1'b1}} << $past(rnd_code))) == '0)); // R10

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (64'((gain_out >= $past(gain_out)) ? (gain_out - $past(gain_out))
                                                         : ($past(gain_out) - gain_out))
                      <= MAX_STEP)); // R4

endmodule

bind agc_loop agc_loop_chk #(
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OUT_W(OUT_W),
    .SHIFT_W(SHIFT_W), .RND_W(RND_W), .STEP_UNIT(STEP_UNIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .rnd_code (rnd_code),
    .out_valid(out_valid),
    .out_data (out_data),
    .gain_out (gain_out)
);

// File: tb/tb_agc_loop.sv
module tb_agc_loop;
    localparam int DATA_W = 16, GAIN_W = 16, GAIN_FRAC = 12, OUT_W = 18;
    localparam longint Y_HI = (64'sd1 <<< (OUT_W - 1)) - 1;
    localparam longint Y_LO = -(64'sd1 <<< (OUT_W - 1));
    localparam longint G_HI = (64'sd1 <<< GAIN_W) - 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [7:0]        thres = 8'd10;
    logic [3:0]        step_below = 4'd4, step_above = 4'd3, step_zero = 4'd5, step_full = 4'd6;
    logic [3:0]        zero_mask = 4'd0, rnd_code = 4'd0;
    logic              out_valid;
    logic [OUT_W-1:0]  out_data;
    logic [GAIN_W-1:0] gain_out;

    agc_loop dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .thres(thres), .step_below(step_below), .step_above(step_above),
        .step_zero(step_zero), .step_full(step_full), .zero_mask(zero_mask),
        .rnd_code(rnd_code), .out_valid(out_valid), .out_data(out_data),
        .gain_out(gain_out)
    );

    typedef struct { longint data; longint gain; string tag; } exp_t;
    exp_t   sb_q[$];
    int     n_chk = 0, n_err = 0;
    bit     done = 0;
    longint m_gain = 64'sd1 <<< GAIN_FRAC;
    int     run_kind = 0, run_cnt = 0;

    function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // driver: drives one sample and pushes the expected result
    task automatic send(input int x, input string tag);
        longint y, mag, top, o, half, stepv;
        bit full, zero;
        exp_t e;
        @(negedge clk);
        in_data  = x[DATA_W-1:0];
        in_valid = 1'b1;
        y = (longint'(x) * m_gain) >>> GAIN_FRAC;
        if (y > Y_HI) y = Y_HI;
        if (y < Y_LO) y = Y_LO;
        mag = (y < 0) ? -y : y;
        if (mag > Y_HI) mag = Y_HI;
        full = (mag == Y_HI);
        zero = !full && ((mag >> zero_mask) == 0);
        top  = mag >> (OUT_W - 1 - 8);
        if (full) begin
            run_cnt  = (run_kind == 2) ? ((run_cnt < 4) ? run_cnt + 1 : 4) : 1;
            run_kind = 2;
        end else if (zero) begin
            run_cnt  = (run_kind == 1) ? ((run_cnt < 4) ? run_cnt + 1 : 4) : 1;
            run_kind = 1;
        end else begin
            run_kind = 0;
            run_cnt  = 0;
        end
        if (full && run_cnt == 4) begin
            stepv = 64'sd1 <<< step_full;  m_gain = m_gain - stepv;
        end else if (zero && run_cnt == 4) begin
            stepv = 64'sd1 <<< step_zero;  m_gain = m_gain + stepv;
        end else if (top > thres) begin
            stepv = 64'sd1 <<< step_above; m_gain = m_gain - stepv;
        end else if (top < thres) begin
            stepv = 64'sd1 <<< step_below; m_gain = m_gain + stepv;
        end
        if (m_gain < 0) m_gain = 0;
        if (m_gain > G_HI) m_gain = G_HI;
        if (rnd_code == 0) begin
            o = y;
        end else begin
            half = 64'sd1 <<< (rnd_code - 1);
            o = ((y + half) >>> rnd_code) <<< rnd_code;
            if (o > Y_HI) o = (Y_HI + 1) - (64'sd1 <<< rnd_code);
        end
        e.data = o; e.gain = m_gain; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // idle cycles: no valid, junk data; gain must hold and no output appears
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) chk(out_valid == 1'b0, "R12", "out_valid idle", out_valid, 0);
            chk(longint'(gain_out) == m_gain, "R12", "gain idle", gain_out, m_gain);
            in_valid = 1'b0;
            in_data  = DATA_W'(16'h5a5a + i * 1311);
        end
    endtask

    // monitor: pops and compares each produced result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(longint'($signed(out_data)) == e.data, e.tag, "out_data",
                    longint'($signed(out_data)), e.data);
                chk(longint'(gain_out) == e.gain, e.tag, "gain_out", gain_out, e.gain);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R2", "watchdog expired", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(gain_out == 16'd4096, "R1", "reset gain", gain_out, 4096);
        chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        chk(out_data == '0, "R1", "reset out_data", out_data, 0);
        rst_n = 1'b1;
        idle(2);

        // R4: equal, below, above
        send(5120, "R4");
        idle(2); thres = 8'd20;
        send(5120, "R4"); send(2000, "R2"); send(-700, "R2");
        idle(2); thres = 8'd5;
        send(-5120, "R4"); send(-300, "R2"); send(6000, "R4");

        // R5 / R8: zero runs, one broken
        idle(2); thres = 8'd0;
        send(0, "R8"); send(0, "R8"); send(0, "R8"); send(100, "R8");
        send(0, "R8"); send(0, "R8"); send(0, "R8");
        send(0, "R5"); send(0, "R5");

        // R7: masked low bits count as zero
        idle(2); zero_mask = 4'd3;
        send(5, "R7"); send(6, "R7"); send(7, "R7"); send(3, "R7"); send(9, "R7");
        idle(2); zero_mask = 4'd0;

        // R10: rounding
        idle(1); rnd_code = 4'd4; thres = 8'd10;
        send(1000, "R10"); send(-1000, "R10"); send(1234, "R10"); send(-8, "R10"); send(7, "R10");
        idle(2); rnd_code = 4'd1;
        send(3, "R10"); send(-3, "R10"); send(-1, "R10");
        idle(2); rnd_code = 4'd0;

        // R9: upper clamp
        step_below = 4'd15; thres = 8'd255;
        send(1000, "R9"); send(1000, "R9"); send(1000, "R9");

        // R3 / R6: clipping and full-scale runs
        send(32767, "R3"); send(32767, "R6"); send(32767, "R6"); send(32767, "R6");
        send(32767, "R6"); send(-32768, "R3"); send(-32768, "R6");
        idle(2); rnd_code = 4'd4;
        send(32767, "R11"); send(-32768, "R11");
        idle(2); rnd_code = 4'd0;

        // R9: lower clamp, then zero run from zero gain
        step_above = 4'd15; thres = 8'd0;
        send(5120, "R9"); send(5120, "R9"); send(5120, "R9");
        send(100, "R5"); send(100, "R5"); send(100, "R5"); send(100, "R5"); send(100, "R5");

        idle(4);
        chk(sb_q.size() == 0, "R2", "pending results", sb_q.size(), 0);
        report();
    end

endmodule